// File: doc/BRIEF.md
# Configurable Split Modulo Adder Pair

This block holds two N-bit parallel-prefix adders that can serve either as two independent residue channel adders or as a single 2N-bit adder modulo 2^(2N)−1. A one-bit mode input chooses between them. The block is purely combinational, so every output follows its inputs within the same cycle.

In channel mode, the lower adder adds two residues modulo 2^N−1. The upper adder adds two residues modulo 2^N+1 held in diminished-one form. A diminished-one residue is a pair (nz, r'). Zero is written (0, 0), and a nonzero value v is written (1, v−1).

In wide mode, the two prefix trees take the lower and upper halves of a carry-save pair (S, C). Each half then takes its carry-in from the other half, and `{hi_o, lo_o}` carries (S+C) mod (2^(2N)−1). Both prefix trees take their carry-in only after the tree, in one extra prefix level. This is why the end-around and cross-coupled carries form no loop.

Top module: `rns_split_adder`

## Requirements
- R1: With mode_i=0 and operands in 0..2^N−2, lo_o equals (m1_a_i+m1_b_i) mod (2^N−1) and lies in 0..2^N−2.
- R2: With mode_i=0, an all-ones operand on one input counts as zero, so lo_o equals the other operand reduced modulo 2^N−1, unless both inputs are all ones.
- R3: With mode_i=0, lo_o is never all ones unless both operands are all ones. A sum that equals the modulus gives lo_o=0.
- R4: With mode_i=0 and both diminished-one flags set (flag 1 = nonzero, bits = value−1), {hi_nz_o, hi_o} encodes (va+vb) mod (2^N+1).
- R5: With mode_i=0 and a zero flag on one operand, the other operand's flag and bits pass to hi_nz_o and hi_o unchanged. Two zero operands give hi_nz_o=0 and hi_o=0, whatever the bits on the zero inputs.
- R6: With mode_i=0, two nonzero operands whose values sum to 2^N+1 give hi_nz_o=0 and hi_o=0.
- R7: With mode_i=1 and S, C each below 2^(2N)−1, {hi_o, lo_o} equals (S+C) mod (2^(2N)−1).
- R8: With mode_i=1, {hi_o, lo_o} is never all ones unless both S and C are all ones. An all-ones S returns C unchanged.
- R9: With mode_i=1, hi_nz_o is 0.
- R10: In wide mode the channel operand inputs have no effect on the outputs. In channel mode the carry-save inputs have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 1 | 0 = two channel adders, 1 = joined 2N-bit adder |
| m1_a_i | input | N | modulo 2^N−1 operand A |
| m1_b_i | input | N | modulo 2^N−1 operand B |
| d1_a_i | input | N | diminished-one bits of operand A |
| d1_a_nz_i | input | 1 | operand A nonzero flag |
| d1_b_i | input | N | diminished-one bits of operand B |
| d1_b_nz_i | input | 1 | operand B nonzero flag |
| cs_s_i | input | 2N | carry-save sum vector for wide mode |
| cs_c_i | input | 2N | carry-save carry vector for wide mode |
| lo_o | output | N | lower adder result (channel result or low half) |
| hi_o | output | N | upper adder result (diminished-one bits or high half) |
| hi_nz_o | output | 1 | diminished-one result nonzero flag, 0 in wide mode |

## Verification
The canonical-form assertions take for granted that the two operands of one addition are never both all ones. That pair is the only input for which the modulo 2^N−1 and 2^(2N)−1 adders return the redundant all-ones zero. The stimulus therefore draws channel and wide operands below the modulus. All-ones values appear only in directed cases where the other operand is a reduced value. Diminished-one operands are drawn with random flags, and the bits are cleared whenever the flag is low. Separate directed cases put nonzero bits behind a zero flag.

// File: rtl/rns_split_pkg.sv
package rns_split_pkg;
  typedef enum logic {
    MODE_CHAN = 1'b0,
    MODE_WIDE = 1'b1
  } add_mode_e;

  function automatic int prefix_levels(int w);
    return (w <= 1) ? 0 : $clog2(w);
  endfunction
endpackage

// File: rtl/rns_prefix_core.sv
module rns_prefix_core #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         grp_g_o,
  output logic         grp_p_o
);
  localparam int LV = rns_split_pkg::prefix_levels(W);

  logic [W-1:0] g_lv [LV+1];
  logic [W-1:0] p_lv [LV+1];
  logic [W-1:0] carry;

  assign g_lv[0] = a_i & b_i;
  assign p_lv[0] = a_i ^ b_i;

  // Kogge-Stone tree, independent of cin
  for (genvar l = 0; l < LV; l++) begin : g_level
    localparam int D = 1 << l;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_op
        assign g_lv[l+1][i] = g_lv[l][i] | (p_lv[l][i] & g_lv[l][i-D]);
        assign p_lv[l+1][i] = p_lv[l][i] & p_lv[l][i-D];
      end else begin : g_pass
        assign g_lv[l+1][i] = g_lv[l][i];
        assign p_lv[l+1][i] = p_lv[l][i];
      end
    end
  end

  // extra level absorbs the late carry-in
  assign carry[0] = cin_i;
  for (genvar i = 1; i < W; i++) begin : g_fast
    assign carry[i] = g_lv[LV][i-1] | (p_lv[LV][i-1] & cin_i);
  end

  assign sum_o   = p_lv[0] ^ carry;
  assign grp_g_o = g_lv[LV][W-1];
  assign grp_p_o = p_lv[LV][W-1];
endmodule

// File: rtl/rns_d1_adjust.sv
module rns_d1_adjust #(
  parameter int W = 8
) (
  input  logic         chan_en_i,
  input  logic [W-1:0] a_i,
  input  logic         a_nz_i,
  input  logic [W-1:0] b_i,
  input  logic         b_nz_i,
  input  logic [W-1:0] raw_i,
  input  logic         grp_p_i,
  output logic [W-1:0] res_o,
  output logic         nz_o
);
  always_comb begin
    res_o = raw_i;
    nz_o  = 1'b0;
    if (chan_en_i) begin
      unique case ({a_nz_i, b_nz_i})
        2'b00: begin res_o = '0;  nz_o = 1'b0; end
        2'b10: begin res_o = a_i; nz_o = 1'b1; end
        2'b01: begin res_o = b_i; nz_o = 1'b1; end
        default: begin
          res_o = raw_i;
          nz_o  = ~grp_p_i;  // x'+y' all-propagate means sum hits 2^W+1
        end
      endcase
    end
  end

  always_comb begin
    if (chan_en_i && a_nz_i && b_nz_i && !nz_o)
      AST_D1_ZERO_BITS: assert (raw_i == '0); // R6
  end
endmodule

// File: rtl/rns_split_adder.sv
module rns_split_adder
  import rns_split_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           mode_i,
  input  logic [N-1:0]   m1_a_i,
  input  logic [N-1:0]   m1_b_i,
  input  logic [N-1:0]   d1_a_i,
  input  logic           d1_a_nz_i,
  input  logic [N-1:0]   d1_b_i,
  input  logic           d1_b_nz_i,
  input  logic [2*N-1:0] cs_s_i,
  input  logic [2*N-1:0] cs_c_i,
  output logic [N-1:0]   lo_o,
  output logic [N-1:0]   hi_o,
  output logic           hi_nz_o
);
  localparam int WW = 2 * N;

  add_mode_e    mode;
  logic         wide_sel;
  logic [N-1:0] lo_a, lo_b, hi_a, hi_b;
  logic [N-1:0] lo_sum, hi_sum;
  logic         lo_g, lo_p, hi_g, hi_p;
  logic         lo_cin, hi_cin;

  assign mode     = add_mode_e'(mode_i);
  assign wide_sel = (mode == MODE_WIDE);

  // operand steering
  assign lo_a = wide_sel ? cs_s_i[N-1:0]  : m1_a_i;
  assign lo_b = wide_sel ? cs_c_i[N-1:0]  : m1_b_i;
  assign hi_a = wide_sel ? cs_s_i[WW-1:N] : d1_a_i;
  assign hi_b = wide_sel ? cs_c_i[WW-1:N] : d1_b_i;

  // carry-in selection: end-around per channel, cross-coupled when joined
  always_comb begin
    if (wide_sel) begin
      lo_cin = hi_g | (hi_p & (lo_g | lo_p));
      hi_cin = lo_g | (lo_p & (hi_g | hi_p));
    end else begin
      lo_cin = lo_g | lo_p;
      hi_cin = ~hi_g;
    end
  end

  rns_prefix_core #(.W(N)) u_lo (
    .a_i(lo_a), .b_i(lo_b), .cin_i(lo_cin),
    .sum_o(lo_sum), .grp_g_o(lo_g), .grp_p_o(lo_p)
  );

  rns_prefix_core #(.W(N)) u_hi (
    .a_i(hi_a), .b_i(hi_b), .cin_i(hi_cin),
    .sum_o(hi_sum), .grp_g_o(hi_g), .grp_p_o(hi_p)
  );

  rns_d1_adjust #(.W(N)) u_d1 (
    .chan_en_i(~wide_sel),
    .a_i(d1_a_i), .a_nz_i(d1_a_nz_i),
    .b_i(d1_b_i), .b_nz_i(d1_b_nz_i),
    .raw_i(hi_sum), .grp_p_i(hi_p),
    .res_o(hi_o), .nz_o(hi_nz_o)
  );

  assign lo_o = lo_sum;

  always_comb begin
    if (!mode_i && !((&m1_a_i) && (&m1_b_i)))
      AST_M1_CANON: assert (!(&lo_o)); // R3
    if (mode_i && !((&cs_s_i) && (&cs_c_i)))
      AST_WIDE_CANON: assert (!(&{hi_o, lo_o})); // R8
    if (mode_i)
      AST_WIDE_FLAG_LOW: assert (!hi_nz_o); // R9
    if (!mode_i && !d1_a_nz_i && !d1_b_nz_i)
      AST_D1_BOTH_ZERO: assert (!hi_nz_o && hi_o == '0); // R5
    if (!mode_i && !d1_a_nz_i && d1_b_nz_i)
      AST_D1_PASS_B: assert (hi_nz_o && hi_o == d1_b_i); // R5
  end
endmodule

// File: tb/rns_split_adder_tb.sv
module rns_split_adder_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] ma;
    logic [7:0] mb;
    logic [7:0] da;
    logic       daz;
    logic [7:0] db;
    logic       dbz;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{8'd0,   8'd0,   8'd0,   1'b1, 8'd0,   1'b1},
    '{8'd1,   8'd2,   8'd3,   1'b1, 8'd4,   1'b1},
    '{8'd254, 8'd1,   8'd255, 1'b1, 8'd0,   1'b1},
    '{8'd253, 8'd253, 8'd255, 1'b1, 8'd255, 1'b1},
    '{8'd128, 8'd127, 8'd127, 1'b1, 8'd127, 1'b1},
    '{8'd100, 8'd200, 8'd10,  1'b1, 8'd245, 1'b1},
    '{8'd17,  8'd0,   8'd200, 1'b1, 8'd100, 1'b1},
    '{8'd0,   8'd77,  8'd254, 1'b1, 8'd1,   1'b1},
    '{8'd200, 8'd54,  8'd128, 1'b1, 8'd128, 1'b1},
    '{8'd99,  8'd155, 8'd64,  1'b1, 8'd33,  1'b1}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  logic        mode8, xz8, yz8, nz8;
  logic [7:0]  a8, b8, x8, y8, lo8, hi8;
  logic [15:0] s8, c8;
  logic        mode4, xz4, yz4, nz4;
  logic [3:0]  a4, b4, x4, y4, lo4, hi4;
  logic [7:0]  s4, c4;

  rns_split_adder #(.N(8)) u_dut (
    .mode_i(mode8), .m1_a_i(a8), .m1_b_i(b8),
    .d1_a_i(x8), .d1_a_nz_i(xz8), .d1_b_i(y8), .d1_b_nz_i(yz8),
    .cs_s_i(s8), .cs_c_i(c8), .lo_o(lo8), .hi_o(hi8), .hi_nz_o(nz8)
  );

  rns_split_adder #(.N(4)) u_dut_n4 (
    .mode_i(mode4), .m1_a_i(a4), .m1_b_i(b4),
    .d1_a_i(x4), .d1_a_nz_i(xz4), .d1_b_i(y4), .d1_b_nz_i(yz4),
    .cs_s_i(s4), .cs_c_i(c4), .lo_o(lo4), .hi_o(hi4), .hi_nz_o(nz4)
  );

  function automatic longint m1_ref(longint a, longint b, int n);
    longint md = (longint'(1) << n) - 1;
    longint va = (a == md) ? 0 : a;
    longint vb = (b == md) ? 0 : b;
    return (va + vb) % md;
  endfunction

  function automatic longint d1_ref(longint a, bit az, longint b, bit bz, int n);
    longint md = (longint'(1) << n) + 1;
    longint va = az ? a + 1 : 0;
    longint vb = bz ? b + 1 : 0;
    return (va + vb) % md;
  endfunction

  function automatic longint wide_ref(longint s, longint c, int n);
    longint md = (longint'(1) << (2 * n)) - 1;
    return ((s % md) + (c % md)) % md;
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step_drive();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic settle();
    #(CLK_PERIOD/4);
  endtask

  task automatic chan_case(int n, longint ma, longint mb, longint da, bit daz,
                           longint db, bit dbz, string tm, string td);
    longint dv, lo, hi, nz;
    step_drive();
    if (n == 8) begin
      mode8 = 1'b0; a8 = 8'(ma); b8 = 8'(mb);
      x8 = 8'(da); xz8 = daz; y8 = 8'(db); yz8 = dbz;
    end else begin
      mode4 = 1'b0; a4 = 4'(ma); b4 = 4'(mb);
      x4 = 4'(da); xz4 = daz; y4 = 4'(db); yz4 = dbz;
    end
    settle();
    lo = (n == 8) ? longint'(lo8) : longint'(lo4);
    hi = (n == 8) ? longint'(hi8) : longint'(hi4);
    nz = (n == 8) ? longint'(nz8) : longint'(nz4);
    check(tm, "mod 2^n-1 sum", lo, m1_ref(ma, mb, n));
    dv = d1_ref(da, daz, db, dbz, n);
    check(td, "d1 flag", nz, (dv != 0) ? 1 : 0);
    check(td, "d1 bits", hi, (dv != 0) ? dv - 1 : 0);
  endtask

  task automatic wide_case(int n, longint s, longint c, string tag);
    longint res, nz;
    step_drive();
    if (n == 8) begin mode8 = 1'b1; s8 = 16'(s); c8 = 16'(c); end
    else        begin mode4 = 1'b1; s4 = 8'(s);  c4 = 8'(c);  end
    settle();
    res = (n == 8) ? longint'({hi8, lo8}) : longint'({hi4, lo4});
    nz  = (n == 8) ? longint'(nz8) : longint'(nz4);
    check(tag, "wide sum", res, wide_ref(s, c, n));
    check("R9", "wide flag", nz, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    longint ref_res;
    mode8 = 0; a8 = 0; b8 = 0; x8 = 0; y8 = 0; xz8 = 0; yz8 = 0; s8 = 0; c8 = 0;
    mode4 = 0; a4 = 0; b4 = 0; x4 = 0; y4 = 0; xz4 = 0; yz4 = 0; s4 = 0; c4 = 0;
    settle();
    // idle state: all-zero inputs
    check("R5", "idle lo8", longint'(lo8), 0);
    check("R5", "idle hi8", longint'(hi8), 0);
    check("R5", "idle nz8", longint'(nz8), 0);

    for (int i = 0; i < NV; i++)
      chan_case(8, TBL[i].ma, TBL[i].mb, TBL[i].da, TBL[i].daz,
                TBL[i].db, TBL[i].dbz, "R1", "R4");

    for (int i = 0; i < 300; i++) begin
      int n = (i % 2 == 0) ? 8 : 4;
      longint md = (longint'(1) << n) - 1;
      bit az = 1'($urandom), bz = 1'($urandom);
      longint da = az ? longint'($urandom % (md + 1)) : 0;
      longint db = bz ? longint'($urandom % (md + 1)) : 0;
      chan_case(n, longint'($urandom % md), longint'($urandom % md),
                da, az, db, bz, "R1", "R4");
    end

    // R2: all-ones operand is zero
    chan_case(8, 255, 37, 0, 0, 0, 0, "R2", "R5");
    chan_case(8, 0, 255, 0, 0, 0, 0, "R2", "R5");
    chan_case(4, 15, 9, 0, 0, 0, 0, "R2", "R5");
    // R3: sum equal to modulus folds to zero
    chan_case(8, 254, 1, 0, 0, 0, 0, "R3", "R5");
    chan_case(4, 7, 8, 0, 0, 0, 0, "R3", "R5");
    // R5: zero operand passes the other, bits behind a zero flag ignored
    chan_case(8, 3, 4, 8'd90, 1, 8'd200, 0, "R1", "R5");
    chan_case(8, 3, 4, 8'd55, 0, 8'd255, 1, "R1", "R5");
    chan_case(8, 3, 4, 8'd55, 0, 8'd77, 0, "R1", "R5");
    chan_case(4, 3, 4, 4'd15, 0, 4'd6, 1, "R1", "R5");
    // R6: nonzero operands summing to 2^n+1
    chan_case(8, 0, 0, 8'd0, 1, 8'd255, 1, "R1", "R6");
    chan_case(8, 0, 0, 8'd100, 1, 8'd155, 1, "R1", "R6");
    chan_case(4, 0, 0, 4'd7, 1, 4'd8, 1, "R1", "R6");

    for (int i = 0; i < 300; i++) begin
      int n = (i % 2 == 0) ? 8 : 4;
      longint md = (longint'(1) << (2 * n)) - 1;
      wide_case(n, longint'($urandom % md), longint'($urandom % md), "R7");
    end
    wide_case(8, 65534, 1, "R7");
    wide_case(8, 65534, 65534, "R7");
    wide_case(8, 255, 65280, "R7");
    wide_case(8, 256, 65279, "R7");
    wide_case(4, 2, 253, "R7");
    wide_case(4, 254, 254, "R7");
    // R8: all-ones S returns C, modulus sum folds to zero
    wide_case(8, 65535, 12345, "R8");
    wide_case(4, 255, 77, "R8");
    wide_case(8, 32768, 32767, "R8");

    // R10: channel inputs ignored in wide mode
    wide_case(8, 40000, 20000, "R7");
    ref_res = longint'({hi8, lo8});
    step_drive();
    a8 = 8'd200; b8 = 8'd100; x8 = 8'd33; xz8 = 1; y8 = 8'd44; yz8 = 1;
    settle();
    check("R10", "wide vs channel inputs", longint'({hi8, lo8}), ref_res);
    check("R10", "wide flag after channel change", longint'(nz8), 0);
    // R10: carry-save inputs ignored in channel mode
    chan_case(8, 10, 20, 8'd5, 1, 8'd6, 1, "R1", "R4");
    step_drive();
    s8 = 16'hBEEF; c8 = 16'h1234;
    settle();
    check("R10", "chan lo vs cs inputs", longint'(lo8), 30);
    check("R10", "chan hi vs cs inputs", longint'(hi8), 12);
    check("R10", "chan flag vs cs inputs", longint'(nz8), 1);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule